// File: doc/BRIEF.md
# Automatic Level Control Gain Controller

This block closes the digital side of a gain loop around a microphone preamplifier. It keeps the loudest sample magnitude seen between two ticks of a slow timebase, sorts that peak into one of three classes (too loud, inside the target window, too quiet), and moves a 6-bit preamp gain code one step at a time. The code covers -12 dB to +35.25 dB in 0.75 dB steps. Code 16 is 0 dB.

There are two timing modes. The level-control mode uses slow steps. The peak-limiter mode uses shorter base intervals. A loud peak starts attack counting at once. A quiet peak first waits out a programmable hold time and then starts decay counting. Each interval is a base count of ticks shifted left by a 4-bit setting, so each setting doubles the interval. The tick comes from a divider on the system clock, so every interval scales with that clock.

While the enable input is low, the gain code follows a manual code and all step timers stay cleared.

Top module: `agc_gain_ctrl`

## Requirements
- R1: While `rst` is high, the gain code is 16 (0 dB) at the next clock edge.
- R2: While `en` is low, `gain` equals the `manual_gain` of the previous cycle. Ticks and samples have no effect. After `en` rises, counting starts fresh from the manual code.
- R3: The threshold T is looked up from `target_code`, taking k = 14 - min(code, 14). The base value is 27571, 23198, 19519 or 16423 for k mod 4 = 0, 1, 2 or 3. The base is shifted right by k/4 and then left by MAG_W-16. A peak above T is loud. A peak below T>>1 is quiet. Codes 14 and 15 both give 27571.
- R4: Attack: while consecutive ticks are loud, the gain falls by one on every atk_len-th loud tick. There is no hold. atk_len = A << `attack_sel`.
- R5: Decay: while consecutive ticks are quiet, the gain rises by one on quiet tick number hold_len + m*dcy_len, for m = 1, 2, and so on. dcy_len = D << `decay_sel`.
- R6: hold_len is 0 when `hold_sel` is 0, and 8 << (`hold_sel` - 1) otherwise. A loud or in-window tick restarts the hold.
- R7: With `mode` = 0 (level control), A = 4 and D = 16. With `mode` = 1 (limiter), A = 1 and D = 4.
- R8: An in-window tick leaves the gain unchanged and restarts both attack and decay counting.
- R9: The gain stops at 0 and at 63 and never wraps.
- R10: While enabled, the gain changes only at the clock edge of a `tick` cycle, and by at most one code.
- R11: The peak judged at a tick covers valid samples from the previous tick cycle, that cycle included, up to the cycle before this tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Loop enable; when low the manual code is used |
| mode | input | 1 | 0 = level control timing, 1 = limiter timing |
| target_code | input | 4 | Target level, 1.5 dB per code, 0 = -22.5 dB |
| hold_sel | input | 4 | Hold time setting |
| decay_sel | input | 4 | Decay (ramp-up) step interval setting |
| attack_sel | input | 4 | Attack (ramp-down) step interval setting |
| manual_gain | input | 6 | Gain code used while disabled |
| tick | input | 1 | One-cycle timebase strobe |
| smp_vld | input | 1 | Sample magnitude valid |
| smp_mag | input | 16 | Unsigned sample magnitude |
| gain | output | 6 | Registered preamp gain code |

## Verification
The assertions assume that `tick` is a single-cycle strobe. They also assume that the settings change only while `en` is low, because the interval lengths are registered and a change during a run would alter counting in mid-interval. The stimulus follows both rules. Settings and the manual code are applied with the loop disabled. Every tick is a one-cycle pulse after three sample cycles. Random magnitudes are drawn inside chosen classes, with a class held over runs of ticks so that attack, hold and decay counts complete. Directed cases cover both saturation ends, hold interruption, target codes 14 and 15, and a loud sample placed in the tick cycle itself.

// File: rtl/agc_pkg.sv
package agc_pkg;

  localparam int TGT_W = 4;
  localparam int TGT_MAX = 14;

  typedef enum logic [1:0] {
    LVL_OK    = 2'b00,
    LVL_LOUD  = 2'b01,
    LVL_QUIET = 2'b10
  } lvl_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ATK  = 2'b01,
    PH_HOLD = 2'b10,
    PH_DCY  = 2'b11
  } ph_e;

  // Threshold mantissa for 1.5 dB steps inside one 6 dB octave, 16-bit scale.
  function automatic logic [15:0] tgt_mant(input logic [1:0] j);
    logic [15:0] m;
    unique case (j)
      2'd0: m = 16'd27571;
      2'd1: m = 16'd23198;
      2'd2: m = 16'd19519;
      default: m = 16'd16423;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/agc_level_det.sv
module agc_level_det
  import agc_pkg::*;
#(
  parameter int MAG_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   tick,
  input  logic                   smp_vld,
  input  logic [MAG_W-1:0]       smp_mag,
  input  logic [TGT_W-1:0]       target_code,
  output lvl_e                   lvl
);

  localparam int MAG_SH = MAG_W - 16;

  logic [MAG_W-1:0] peak_q;
  logic [MAG_W-1:0] thr;
  logic [TGT_W-1:0] k;

  // Attenuation index below the highest target.
  always_comb begin
    if (target_code >= TGT_W'(TGT_MAX)) k = '0;
    else                                k = TGT_W'(TGT_MAX) - target_code;
  end

  always_comb thr = (MAG_W'(tgt_mant(k[1:0])) << MAG_SH) >> k[3:2];

  // Peak of the samples since the previous tick; the tick-cycle sample opens the next window.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      peak_q <= '0;
    end else if (tick) begin
      peak_q <= smp_vld ? smp_mag : '0;
    end else if (smp_vld && (smp_mag > peak_q)) begin
      peak_q <= smp_mag;
    end
  end

  always_comb begin
    if (peak_q > thr)             lvl = LVL_LOUD;
    else if (peak_q < (thr >> 1)) lvl = LVL_QUIET;
    else                          lvl = LVL_OK;
  end

endmodule

// File: rtl/agc_interval_sel.sv
module agc_interval_sel #(
  parameter int unsigned ALC_ATK   = 4,
  parameter int unsigned ALC_DCY   = 16,
  parameter int unsigned LIM_ATK   = 1,
  parameter int unsigned LIM_DCY   = 4,
  parameter int unsigned HOLD_BASE = 8,
  parameter int          SEL_W     = 4,
  parameter int          CNT_W     = 20,
  parameter bit          LEN_REG   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic [SEL_W-1:0] hold_sel,
  input  logic [SEL_W-1:0] decay_sel,
  input  logic [SEL_W-1:0] attack_sel,
  output logic [CNT_W-1:0] atk_len,
  output logic [CNT_W-1:0] dcy_len,
  output logic [CNT_W-1:0] hold_len
);

  logic [CNT_W-1:0] atk_b, dcy_b;
  logic [CNT_W-1:0] atk_c, dcy_c, hold_c;

  assign atk_b  = mode ? CNT_W'(LIM_ATK) : CNT_W'(ALC_ATK);
  assign dcy_b  = mode ? CNT_W'(LIM_DCY) : CNT_W'(ALC_DCY);
  assign atk_c  = atk_b << attack_sel;
  assign dcy_c  = dcy_b << decay_sel;
  assign hold_c = (hold_sel == '0) ? '0 : (CNT_W'(HOLD_BASE) << (hold_sel - 1'b1));

  generate
    if (LEN_REG) begin : g_reg
      // Registered lengths keep the barrel shifters out of the step-control path.
      always_ff @(posedge clk) begin
        if (rst) begin
          atk_len  <= CNT_W'(ALC_ATK);
          dcy_len  <= CNT_W'(ALC_DCY);
          hold_len <= '0;
        end else begin
          atk_len  <= atk_c;
          dcy_len  <= dcy_c;
          hold_len <= hold_c;
        end
      end
    end else begin : g_comb
      assign atk_len  = atk_c;
      assign dcy_len  = dcy_c;
      assign hold_len = hold_c;
    end
  endgenerate

endmodule

// File: rtl/agc_step_ctrl.sv
module agc_step_ctrl
  import agc_pkg::*;
#(
  parameter int GAIN_W   = 6,
  parameter int CNT_W    = 20,
  parameter int RST_GAIN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  lvl_e              lvl,
  input  logic [CNT_W-1:0]  atk_len,
  input  logic [CNT_W-1:0]  dcy_len,
  input  logic [CNT_W-1:0]  hold_len,
  input  logic [GAIN_W-1:0] manual_gain,
  output logic [GAIN_W-1:0] gain
);

  ph_e              ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [GAIN_W-1:0] gain_q;

  logic [CNT_W-1:0]  n_atk, n_hold, n_dcy;
  logic              use_dcy;
  logic [GAIN_W-1:0] gain_up, gain_dn;

  always_comb begin
    n_atk   = (ph_q == PH_ATK)  ? cnt_q + CNT_W'(1) : CNT_W'(1);
    n_hold  = (ph_q == PH_HOLD) ? cnt_q + CNT_W'(1) : CNT_W'(1);
    n_dcy   = (ph_q == PH_DCY)  ? cnt_q + CNT_W'(1) : CNT_W'(1);
    use_dcy = (ph_q == PH_DCY) || ((ph_q != PH_HOLD) && (hold_len == '0));
    gain_up = (gain_q == '1) ? gain_q : gain_q + 1'b1;
    gain_dn = (gain_q == '0) ? gain_q : gain_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= GAIN_W'(RST_GAIN);
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
    end else if (!en) begin
      gain_q <= manual_gain;
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
    end else if (tick) begin
      unique case (lvl)
        LVL_LOUD: begin
          ph_q <= PH_ATK;
          if (n_atk >= atk_len) begin
            gain_q <= gain_dn;
            cnt_q  <= '0;
          end else begin
            cnt_q  <= n_atk;
          end
        end
        LVL_QUIET: begin
          if (use_dcy) begin
            ph_q <= PH_DCY;
            if (n_dcy >= dcy_len) begin
              gain_q <= gain_up;
              cnt_q  <= '0;
            end else begin
              cnt_q  <= n_dcy;
            end
          end else if (n_hold >= hold_len) begin
            ph_q  <= PH_DCY;
            cnt_q <= '0;
          end else begin
            ph_q  <= PH_HOLD;
            cnt_q <= n_hold;
          end
        end
        default: begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign gain = gain_q;

endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int          MAG_W     = 16,
  parameter int          GAIN_W    = 6,
  parameter int          SEL_W     = 4,
  parameter int          RST_GAIN  = 16,
  parameter int unsigned ALC_ATK   = 4,
  parameter int unsigned ALC_DCY   = 16,
  parameter int unsigned LIM_ATK   = 1,
  parameter int unsigned LIM_DCY   = 4,
  parameter int unsigned HOLD_BASE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              mode,
  input  logic [TGT_W-1:0]  target_code,
  input  logic [SEL_W-1:0]  hold_sel,
  input  logic [SEL_W-1:0]  decay_sel,
  input  logic [SEL_W-1:0]  attack_sel,
  input  logic [GAIN_W-1:0] manual_gain,
  input  logic              tick,
  input  logic              smp_vld,
  input  logic [MAG_W-1:0]  smp_mag,
  output logic [GAIN_W-1:0] gain
);

  localparam int unsigned MAX_AD   = (ALC_ATK > ALC_DCY) ? ALC_ATK : ALC_DCY;
  localparam int unsigned MAX_LIM  = (LIM_ATK > LIM_DCY) ? LIM_ATK : LIM_DCY;
  localparam int unsigned MAX_TD   = (MAX_AD > MAX_LIM) ? MAX_AD : MAX_LIM;
  localparam int unsigned MAX_BASE = (MAX_TD > HOLD_BASE) ? MAX_TD : HOLD_BASE;
  localparam int          CNT_W    = $clog2(MAX_BASE + 1) + (1 << SEL_W) - 1;

  lvl_e             lvl;
  logic [CNT_W-1:0] atk_len, dcy_len, hold_len;

  agc_level_det #(.MAG_W(MAG_W)) u_det (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .tick        (tick),
    .smp_vld     (smp_vld),
    .smp_mag     (smp_mag),
    .target_code (target_code),
    .lvl         (lvl)
  );

  agc_interval_sel #(
    .ALC_ATK   (ALC_ATK),
    .ALC_DCY   (ALC_DCY),
    .LIM_ATK   (LIM_ATK),
    .LIM_DCY   (LIM_DCY),
    .HOLD_BASE (HOLD_BASE),
    .SEL_W     (SEL_W),
    .CNT_W     (CNT_W),
    .LEN_REG   (1'b1)
  ) u_len (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .hold_sel   (hold_sel),
    .decay_sel  (decay_sel),
    .attack_sel (attack_sel),
    .atk_len    (atk_len),
    .dcy_len    (dcy_len),
    .hold_len   (hold_len)
  );

  agc_step_ctrl #(
    .GAIN_W   (GAIN_W),
    .CNT_W    (CNT_W),
    .RST_GAIN (RST_GAIN)
  ) u_step (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .tick        (tick),
    .lvl         (lvl),
    .atk_len     (atk_len),
    .dcy_len     (dcy_len),
    .hold_len    (hold_len),
    .manual_gain (manual_gain),
    .gain        (gain)
  );

endmodule

// File: rtl/agc_gain_ctrl_chk.sv
module agc_gain_ctrl_chk #(
  parameter int GAIN_W   = 6,
  parameter int RST_GAIN = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              tick,
  input logic [GAIN_W-1:0] manual_gain,
  input logic [GAIN_W-1:0] gain
);

  AST_RESET_GAIN: assert property (@(posedge clk) rst |=> gain == GAIN_W'(RST_GAIN)); // R1

  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> gain == $past(manual_gain)); // R2

  AST_STABLE_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(gain)); // R10

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |=> ((gain == $past(gain)) || (32'(gain) == 32'($past(gain)) + 1)
                      || (32'(gain) + 1 == 32'($past(gain))))); // R10

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
    (en && tick && gain == '1) |=> gain != '0); // R9

  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    (en && tick && gain == '0) |=> gain != '1); // R9

endmodule

bind agc_gain_ctrl agc_gain_ctrl_chk #(.GAIN_W(GAIN_W), .RST_GAIN(RST_GAIN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .tick        (tick),
  .manual_gain (manual_gain),
  .gain        (gain)
);

// File: tb/test_agc_gain_ctrl.sv
module test_agc_gain_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        mode = 1'b0;
  logic [3:0]  target_code = 4'd14;
  logic [3:0]  hold_sel = '0, decay_sel = '0, attack_sel = '0;
  logic [5:0]  manual_gain = 6'd20;
  logic        tick = 1'b0;
  logic        smp_vld = 1'b0;
  logic [15:0] smp_mag = '0;
  logic [5:0]  gain;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // reference model state
  int m_gain, m_run, m_prev, m_carry;
  bit m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_gain_ctrl i_agc_gain_ctrl (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .target_code(target_code),
    .hold_sel(hold_sel), .decay_sel(decay_sel), .attack_sel(attack_sel),
    .manual_gain(manual_gain), .tick(tick), .smp_vld(smp_vld), .smp_mag(smp_mag),
    .gain(gain)
  );

  function automatic int f_thr(input int c);
    int k, m;
    k = (c >= 14) ? 0 : 14 - c;
    case (k % 4)
      0: m = 27571;
      1: m = 23198;
      2: m = 19519;
      default: m = 16423;
    endcase
    return m >> (k / 4);
  endfunction

  // 1 = loud, 2 = quiet, 0 = in window (R3)
  function automatic int f_cls(input int mag, input int c);
    int t;
    t = f_thr(c);
    if (mag > t) return 1;
    if (mag < t / 2) return 2;
    return 0;
  endfunction

  function automatic int f_atk();  return (mode ? 1 : 4) << attack_sel;  endfunction // R7
  function automatic int f_dcy();  return (mode ? 4 : 16) << decay_sel;  endfunction // R7
  function automatic int f_hold(); return (hold_sel == 0) ? 0 : (8 << (hold_sel - 1)); endfunction // R6

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input bit md, input int tc, input int hs, input int ds, input int as_, input int man);
    en = 1'b0;
    mode = md; target_code = 4'(tc); hold_sel = 4'(hs); decay_sel = 4'(ds); attack_sel = 4'(as_);
    manual_gain = 6'(man);
    repeat (2) @(negedge clk);
    chk("R2 manual gain while disabled", int'(gain), man);
    m_gain = man; m_run = 0; m_prev = 0; m_carry = 0; m_en = 1'b0;
  endtask

  task automatic go();
    en = 1'b1; m_en = 1'b1;
  endtask

  // one tick window: three sample cycles, then the tick cycle (R11: its sample opens the next window)
  task automatic do_tick(input int mag, input bit tv, input int tmag);
    int eff, c, st;
    string tag;
    tick = 1'b0; smp_vld = 1'b1; smp_mag = 16'(mag);
    @(negedge clk);
    chk("R10 no change between ticks", int'(gain), m_gain);
    repeat (2) @(negedge clk);
    tick = 1'b1; smp_vld = tv; smp_mag = 16'(tmag);
    @(negedge clk);
    tick = 1'b0; smp_vld = 1'b0;
    eff = (mag > m_carry) ? mag : m_carry;
    m_carry = m_en ? (tv ? tmag : 0) : 0;
    tag = "R2 disabled ignores samples";
    if (m_en) begin
      c = f_cls(eff, int'(target_code));
      if (c == 0) m_run = 0;
      else if (c == m_prev) m_run++;
      else m_run = 1;
      m_prev = c;
      st = 0;
      if (c == 1) begin
        tag = "R4 attack";
        if (m_run % f_atk() == 0) st = -1;
      end else if (c == 2) begin
        tag = "R5 decay/hold";
        if (m_run > f_hold() && ((m_run - f_hold()) % f_dcy()) == 0) st = 1;
      end else tag = "R8 in window";
      m_gain = m_gain + st;
      if (m_gain < 0) m_gain = 0;   // R9
      if (m_gain > 63) m_gain = 63; // R9
    end
    chk(tag, int'(gain), m_gain);
  endtask

  task automatic ticks(input int n, input int mag);
    for (int i = 0; i < n; i++) do_tick(mag, 1'b0, 0);
  endtask

  function automatic int rnd_mag(input int c, input int tc);
    int t;
    t = f_thr(tc);
    if (c == 1) return t + 1 + int'($urandom % (65535 - t));
    if (c == 2) return int'($urandom % (t / 2));
    return t / 2 + int'($urandom % (t - t / 2 + 1));
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int cls, tc;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    chk("R1 reset gain", int'(gain), 16);
    rst = 1'b0;
    @(negedge clk);

    // R2: disabled loop ignores loud samples and ticks
    cfg(1'b1, 14, 0, 0, 0, 45);
    ticks(3, 60000);
    manual_gain = 6'd7; m_gain = 7;
    @(negedge clk);
    chk("R2 follows manual", int'(gain), 7);

    // R9 bottom: limiter, attack length 1
    cfg(1'b1, 14, 0, 0, 0, 2); go();
    ticks(5, 60000);
    chk("R9 floor at 0", int'(gain), 0);

    // R9 top: limiter decay length 4, no hold
    cfg(1'b1, 14, 0, 0, 0, 61); go();
    ticks(16, 100);
    chk("R9 ceiling at 63", int'(gain), 63);

    // R7 level-control attack length 4 and decay 16
    cfg(1'b0, 14, 0, 0, 0, 30); go();
    ticks(8, 60000);
    chk("R7 ALC attack two steps", int'(gain), 28);
    ticks(16, 100);
    chk("R7 ALC decay one step", int'(gain), 29);

    // R6 hold: 8 quiet ticks, then limiter decay 4; a loud tick restarts hold
    cfg(1'b1, 14, 1, 0, 0, 30); go();
    ticks(5, 100);
    do_tick(60000, 1'b0, 0);
    ticks(11, 100);
    chk("R6 hold restarted by loud tick", int'(gain), 29);
    ticks(1, 100);
    chk("R6 first rise after hold plus decay", int'(gain), 30);
    cfg(1'b1, 14, 2, 1, 0, 30); go();
    ticks(24, 100);
    chk("R6 hold 16 plus decay 8", int'(gain), 31);

    // R8: in-window tick restarts attack counting
    cfg(1'b0, 14, 0, 0, 0, 30); go();
    ticks(3, 60000); ticks(1, 20000); ticks(3, 60000);
    chk("R8 window restarts attack", int'(gain), 30);

    // R3: codes 14 and 15 share one threshold
    cfg(1'b1, 15, 0, 0, 0, 30); go();
    ticks(1, 27571);
    chk("R3 code 15 at threshold not loud", int'(gain), 30);
    ticks(1, 27572);
    chk("R3 code 15 above threshold loud", int'(gain), 29);
    cfg(1'b1, 0, 0, 0, 0, 30); go();
    ticks(1, 2440);
    chk("R3 code 0 threshold 2439", int'(gain), 29);

    // R11: loud sample in the tick cycle counts toward the next window
    cfg(1'b1, 14, 0, 0, 0, 30); go();
    do_tick(20000, 1'b1, 60000);
    chk("R11 tick sample not in own window", int'(gain), 30);
    do_tick(20000, 1'b0, 0);
    chk("R11 tick sample in next window", int'(gain), 29);

    // random segments
    for (int s = 0; s < 40; s++) begin
      tc = int'($urandom % 16);
      cfg(1'($urandom % 2), tc, int'($urandom % 3), int'($urandom % 2),
          int'($urandom % 3), int'($urandom % 64));
      go();
      cls = int'($urandom % 3);
      for (int t = 0; t < 24; t++) begin
        if ($urandom % 4 == 0) cls = int'($urandom % 3);
        do_tick(rnd_mag(cls, tc), 1'($urandom % 2), rnd_mag(int'($urandom % 3), tc));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule